// File: doc/BRIEF.md
# Double-Sampling Timing-Error Register

This block is a register cell that detects data arriving too late for the main clock edge. Each bit is captured twice. The main register takes its input on the rising edge of the main clock. A shadow register takes the same input on the rising edge of a delayed clock, which rises later in the same cycle. The shadow copy therefore gets extra settling time and serves as the trusted reference.

When the two captures of a cycle disagree in any bit, a sticky error flag is raised on the following main-clock edge. Surrounding pipeline control answers the flag by pulsing a restore strobe. On that edge the main register is reloaded from the shadow copy and the flag is cleared. The edge after a restore or a reset performs no comparison, because the two copies on that edge do not come from the same sampling instant.

The data width is a parameter. The error flag is the OR of the per-bit mismatches. Reset is synchronous and active high. It is seen by the main register on main-clock edges and by the shadow register on delayed-clock edges.

Top module: `dual_sample_reg`

## Requirements
- R1: While `rst` is high at a main-clock rising edge, `q` becomes all zeros and `err` becomes 0. While `rst` is high at a delayed-clock rising edge, the shadow copy becomes all zeros. A restore issued at the first edge after reset therefore yields `q` = 0.
- R2: At a main-clock rising edge with `rst` and `restore` both low, `q` takes the value `d` had just before that edge. When both captures agree, `err` stays 0.
- R3: At each delayed-clock rising edge with `rst` low, the shadow copy takes the value `d` had just before that edge.
- R4: At a main-clock rising edge with `rst` and `restore` low, `err` becomes 1 when `q` and the shadow copy differ in at least one bit just before that edge. This applies only if the previous edge loaded `q` from `d`. A mismatch in any single bit position is enough.
- R5: Once set, `err` stays 1 at every main-clock edge until an edge with `restore` or `rst` high.
- R6: At a main-clock rising edge with `restore` high and `rst` low, `q` takes the shadow copy held just before that edge, `d` is ignored, and `err` becomes 0. `rst` has priority over `restore`.
- R7: The first main-clock edge after a restore edge or a reset edge performs no comparison. At that edge `err` stays 0 even if `q` and the shadow copy differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; the main register captures on its rising edge |
| dclk | input | 1 | Delayed clock; the shadow register captures on its rising edge, later in the same cycle |
| rst | input | 1 | Synchronous active-high reset |
| restore | input | 1 | Reload the main register from the shadow copy and clear the error flag |
| d | input | W | Data input |
| q | output | W | Main registered data |
| err | output | 1 | Sticky timing-error flag |

## Verification
A corrupted shadow copy has no effect at the ports until a comparison or a restore uses it. It then appears one main-clock edge later, either as `err` rising without a late input or as a wrong `q` after a restore. A lost or stuck comparison-enable bit shows up on the edge right after a restore: `err` rises spuriously when the restored value differs from the new shadow sample. A mishandled sticky flag shows up as `err` dropping on an ordinary on-time edge. The bench sweeps every pair of main and shadow values for a 4-bit register, mixing in restores, so each of these faults reaches the ports within one or two cycles.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    // Source selected for the main register at a main-clock edge.
    typedef enum logic [1:0] {
        MSRC_CLEAR  = 2'd0,
        MSRC_DATA   = 2'd1,
        MSRC_SHADOW = 2'd2
    } main_src_e;

    // Reset wins over restore; otherwise the input data is taken.
    function automatic main_src_e pick_src(input logic rst, input logic restore);
        if (rst)          return MSRC_CLEAR;
        else if (restore) return MSRC_SHADOW;
        else              return MSRC_DATA;
    endfunction

endpackage

// File: rtl/dsr_shadow.sv
module dsr_shadow #(
    parameter int W = 8
) (
    input  logic         dclk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] shadow_q
);

    typedef struct packed {
        logic [W-1:0] val;
    } shadow_state_t;

    shadow_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) st_d.val = '0;
        else     st_d.val = d;
    end

    always_ff @(posedge dclk) begin
        st_q <= st_d;
    end

    assign shadow_q = st_q.val;

endmodule

// File: rtl/dsr_compare.sv
module dsr_compare #(
    parameter int W = 8
) (
    input  logic [W-1:0] main_val,
    input  logic [W-1:0] shadow_val,
    output logic         mismatch
);

    logic [W-1:0] bit_diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_diff[i] = main_val[i] ^ shadow_val[i];
    end

    assign mismatch = |bit_diff;

endmodule

// File: rtl/dsr_main.sv
module dsr_main
    import dsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restore,
    input  logic [W-1:0] d,
    input  logic [W-1:0] shadow_val,
    input  logic         mismatch,
    output logic [W-1:0] q,
    output logic         err
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         err;
        logic         armed;   // last edge loaded val from d
    } main_state_t;

    main_state_t st_d, st_q;
    main_src_e   src;

    always_comb begin
        st_d = st_q;
        src  = pick_src(rst, restore);
        case (src)
            MSRC_CLEAR: begin
                st_d.val   = '0;
                st_d.err   = 1'b0;
                st_d.armed = 1'b0;
            end
            MSRC_SHADOW: begin
                st_d.val   = shadow_val;
                st_d.err   = 1'b0;
                st_d.armed = 1'b0;
            end
            default: begin
                st_d.val   = d;
                st_d.err   = st_q.err | (st_q.armed & mismatch);
                st_d.armed = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q   = st_q.val;
    assign err = st_q.err;

endmodule

// File: rtl/dual_sample_reg.sv
module dual_sample_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         dclk,
    input  logic         rst,
    input  logic         restore,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         err
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] main_q;
    logic         mismatch;

    dsr_shadow #(.W(W)) u_shadow (
        .dclk     (dclk),
        .rst      (rst),
        .d        (d),
        .shadow_q (shadow_q)
    );

    dsr_compare #(.W(W)) u_cmp (
        .main_val   (main_q),
        .shadow_val (shadow_q),
        .mismatch   (mismatch)
    );

    dsr_main #(.W(W)) u_main (
        .clk        (clk),
        .rst        (rst),
        .restore    (restore),
        .d          (d),
        .shadow_val (shadow_q),
        .mismatch   (mismatch),
        .q          (main_q),
        .err        (err)
    );

    assign q = main_q;

endmodule

// File: rtl/dual_sample_reg_chk.sv
module dual_sample_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         dclk,
    input logic         rst,
    input logic         restore,
    input logic [W-1:0] d,
    input logic [W-1:0] q,
    input logic         err,
    input logic [W-1:0] shadow
);

    // R1: reset clears the main register and the flag
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q == '0 && !err));

    // R2: on-time load
    assert_ontime_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!restore) |=> (q == $past(d)));

    // R3: shadow capture on the delayed clock
    assert_shadow_capture_R3: assert property (@(posedge dclk) disable iff (rst)
        (!rst) |=> (shadow == $past(d)));

    // R4: a rising flag needs a prior disagreement
    assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(q != shadow));

    // R5: flag is sticky
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (err && !restore) |=> err);

    // R6: restore loads the shadow copy and clears the flag
    assert_restore_load_R6: assert property (@(posedge clk) disable iff (rst)
        restore |=> (q == $past(shadow) && !err));

    // R7: no comparison on the edge after a restore
    assert_no_cmp_after_restore_R7: assert property (@(posedge clk) disable iff (rst)
        restore ##1 !restore |=> !err);

endmodule

bind dual_sample_reg dual_sample_reg_chk #(.W(W)) u_chk (
    .clk     (clk),
    .dclk    (dclk),
    .rst     (rst),
    .restore (restore),
    .d       (d),
    .q       (q),
    .err     (err),
    .shadow  (shadow_q)
);

// File: tb/dual_sample_reg_bench.sv
`timescale 1ns/1ps
module dual_sample_reg_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         dclk = 1'b0;
    logic         rst = 1'b1;
    logic         restore = 1'b0;
    logic [W-1:0] d = '0;
    logic [W-1:0] q;
    logic         err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state
    logic [W-1:0] m_q = '0;
    logic [W-1:0] m_sh = '0;
    logic         m_err = 1'b0;
    logic         m_arm = 1'b0;

    dual_sample_reg #(.W(W)) u_dual_sample_reg (
        .clk     (clk),
        .dclk    (dclk),
        .rst     (rst),
        .restore (restore),
        .d       (d),
        .q       (q),
        .err     (err)
    );

    // 250 MHz main clock; delayed clock rises 1.5 ns after it
    always #2 clk = ~clk;
    initial begin
        #1.5;
        forever #2 dclk = ~dclk;
    end

    task automatic check_out(input string tag);
        checks++;
        if (q !== m_q) begin
            errors++;
            $display("FAIL %s: q actual=%h expected=%h", tag, q, m_q);
        end
        checks++;
        if (err !== m_err) begin
            errors++;
            $display("FAIL %s: err actual=%b expected=%b", tag, err, m_err);
        end
    endtask

    // Called at edge+2.5 ns. d=a before the next main edge, d=b before the
    // delayed edge (b != a models a late arrival).
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic rs, input string tag);
        d = a;
        restore = rs;
        @(posedge clk);
        #0.7 d = b;
        #1.8;
        if (rs) begin
            m_q   = m_sh;
            m_err = 1'b0;
            m_arm = 1'b0;
        end else begin
            m_err = m_err | (m_arm && (m_q != m_sh));
            m_q   = a;
            m_arm = 1'b1;
        end
        m_sh = b;
        restore = 1'b0;
        check_out(tag);
    endtask

    task automatic reset_step(input logic [W-1:0] b, input string tag);
        rst = 1'b1;
        @(posedge clk);
        #0.7 d = b;
        #1.8;
        m_q = '0; m_err = 1'b0; m_arm = 1'b0; m_sh = '0;
        check_out(tag);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #2.5;
        reset_step(4'h0, "R1 reset");
        reset_step(4'hA, "R1 reset shadow cleared");
        // R1: restore right after reset loads the cleared shadow
        step(4'h5, 4'h5, 1'b1, "R1 shadow zero after reset");
        // R2: on-time data, no error
        step(4'h3, 4'h3, 1'b0, "R2 on-time");
        step(4'h9, 4'h9, 1'b0, "R2 on-time");
        step(4'hF, 4'hF, 1'b0, "R2 on-time");
        // R3/R4: late arrival, flag rises one edge later
        step(4'h6, 4'h7, 1'b0, "R3 late capture");
        step(4'h6, 4'h6, 1'b0, "R4 mismatch sets err");
        // R5: sticky
        step(4'h2, 4'h2, 1'b0, "R5 err sticky");
        step(4'h2, 4'h2, 1'b0, "R5 err sticky");
        // R6: restore loads shadow, clears err
        step(4'h8, 4'h8, 1'b1, "R6 restore");
        // R7: restored value differs from new shadow, no compare
        step(4'h8, 4'h8, 1'b0, "R7 no compare after restore");
        step(4'h8, 4'h8, 1'b0, "R2 after restore");
        // R7 after reset: shadow cleared while q loads d
        reset_step(4'h0, "R1 reset");
        step(4'hC, 4'hC, 1'b0, "R7 no compare after reset");
        step(4'hC, 4'hC, 1'b0, "R2 after reset");
        // R4: each bit position alone
        for (int i = 0; i < W; i++) begin
            reset_step(4'h0, "R1 reset");
            step(4'h0, 4'h0, 1'b0, "R2 arm");
            step(4'h0, 4'(1 << i), 1'b0, "R3 single-bit late");
            step(4'h0, 4'h0, 1'b0, "R4 single-bit err");
            reset_step(4'h0, "R1 reset clears err");
        end
        // R6: rst wins over restore
        step(4'h1, 4'h1, 1'b0, "R2 arm");
        restore = 1'b1;
        reset_step(4'h0, "R6 rst over restore");
        restore = 1'b0;
        // Sweep all main/shadow pairs with periodic restores
        for (int i = 0; i < 256; i++) begin
            step(4'(i), 4'(i >> 4), (i % 5) == 4, "R2 R4 R5 R6 R7 sweep");
        end
        for (int i = 0; i < 256; i++) begin
            step(4'(i >> 4), 4'(i), (i % 7) == 3, "R2 R4 R5 R6 R7 sweep");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule